// File: doc/BRIEF.md
# Status Channel Calendar Generator

This block produces the 2-bit status stream that the receive side of a SPI-4.2-style link sends back to its transmitter. In normal operation it repeats a fixed frame. The frame is one framing word, then a programmable number of passes through a per-port calendar, then a DIP-2 parity word. Each calendar slot carries the 2-bit status of one port. The block pops that status from a small status FIFO that the receive datapath fills in calendar order.

The calendar length and the number of passes are set on two 8-bit inputs. The block latches them only when it is safe to do so. A resync request lets the current frame run to its end and then parks the stream in continuous framing, which is used to retrain the far end. A test input corrupts exactly one DIP-2 word for each time it rises. A FIFO overflow or underflow raises a sticky error flag and forces continuous framing until a resync clears it.

Top module: `status_cal_gen`

## Requirements
- R1: The framing word is 2'b11. It is sent on every cycle of continuous framing, and once as the first word of every frame after continuous framing is left.
- R2: A frame holds exactly len × reps calendar words between its framing word and its DIP-2 word. A value of 0 on `cal_len` or `cal_reps` counts as 256.
- R3: Each calendar slot sends the oldest FIFO entry and pops it, so entries go out in push order. An entry equal to 2'b11 is sent as 2'b10, so a calendar word never matches the framing code.
- R4: The DIP-2 word is bit-wise inverted parity over the calendar words sent since the last framing word. Bit 1 is the XOR of all bit-1 values and bit 0 is the XOR of all bit-0 values, and both bits are inverted.
- R5: `stat_dip_state` is high in exactly the one cycle that carries the DIP-2 word and low in every other cycle.
- R6: A resync request, even a one-cycle pulse, lets the current frame finish with its DIP-2 word. The block then enters continuous framing with `stat_disabled` high, stays there while the request is held, and starts a new frame on the cycle after the request drops.
- R7: `cal_len` and `cal_reps` are latched on the first cycle after reset and on any cycle where continuous framing and the resync request coincide. A change at any other time has no effect on the frame.
- R8: A rising edge on `err_inject` inverts both bits of the next DIP-2 word and no other word. Holding the input high corrupts only that one DIP-2 word.
- R9: A calendar slot that finds the FIFO empty sends 2'b11. On the next cycle `fifo_err` and `stat_disabled` are both high.
- R10: A push into a full FIFO in a cycle without a pop is dropped. On the next cycle `fifo_err` and `stat_disabled` are both high.
- R11: `fifo_err` stays high, and the block stays in continuous framing, until the resync request is raised. That resync clears the flag and empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync_req | input | 1 | Request continuous framing (retrain) |
| err_inject | input | 1 | Rising edge corrupts the next DIP-2 word |
| cal_len | input | 8 | Calendar entries per pass (0 means 256) |
| cal_reps | input | 8 | Calendar passes per frame (0 means 256) |
| stat_push | input | 1 | Push one port status into the FIFO |
| stat_wdata | input | 2 | Port status pushed with `stat_push` |
| stat_out | output | 2 | Outgoing status word |
| stat_disabled | output | 1 | Continuous framing in progress |
| stat_dip_state | output | 1 | Current word is the DIP-2 word |
| fifo_err | output | 1 | Sticky FIFO overflow/underflow flag |

## Verification
The sequencer state is the only register between the inputs and the outputs, and `stat_out` is decoded from it in the same cycle. An input change made before clock edge E therefore shows up on the outputs right after E. A resync pulse shows as `stat_disabled` in the cycle after the frame's DIP-2 word. A fault shows as the error flag and continuous framing in the cycle after the offending slot or push. An injection edge takes effect on the next DIP-2 word, even when the edge arrives in the cycle just before that word. The bench drives inputs and samples outputs on the falling edge. It steps a cycle-exact model of the frame position, the FIFO level and the parity, and compares every output on every cycle against that model.

// File: rtl/scg_pkg.sv
package scg_pkg;
   localparam int STAT_W = 2;
   typedef enum logic [1:0] {
      ST_OFF = 2'd0,
      ST_FRM = 2'd1,
      ST_CAL = 2'd2,
      ST_DIP = 2'd3
   } scg_state_e;
   localparam logic [STAT_W-1:0] FRAME_WORD  = 2'b11;
   localparam logic [STAT_W-1:0] STARVE_WORD = 2'b10;
endpackage

// File: rtl/scg_stat_fifo.sv
module scg_stat_fifo #(
   parameter int DEPTH  = 4,
   parameter int WORD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [WORD_W-1:0] wdata,
   input  logic              pop,
   output logic [WORD_W-1:0] rdata,
   output logic              empty,
   output logic              ovf,
   output logic              unf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
   localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("scg_stat_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [AW-1:0]     rd_q, wr_q;
   logic [CW-1:0]     lvl_q;
   logic              pop_ok, push_ok, full;
   logic [WORD_W-1:0] ent_w [DEPTH];

   assign empty   = (lvl_q == '0);
   assign full    = (lvl_q == FULL_LVL);
   assign pop_ok  = pop && !empty && !flush;
   assign push_ok = push && !flush && (!full || pop_ok);
   assign ovf     = push && !flush && full && !pop_ok;
   assign unf     = pop && empty && !flush;
   assign rdata   = ent_w[rd_q];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [WORD_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          ent_q <= '0;
         else if (push_ok && wr_q == AW'(i))  ent_q <= wdata;
      end
      assign ent_w[i] = ent_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         lvl_q <= '0;
      end else if (flush) begin
         rd_q  <= '0;
         wr_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (pop_ok)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + AW'(1);
         if (push_ok) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + AW'(1);
         if (push_ok && !pop_ok)      lvl_q <= lvl_q + CW'(1);
         else if (pop_ok && !push_ok) lvl_q <= lvl_q - CW'(1);
      end
   end
endmodule

// File: rtl/scg_cal_seq.sv
module scg_cal_seq
   import scg_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             resync_req,
   input  logic             fault,
   input  logic [CNT_W-1:0] cal_len,
   input  logic [CNT_W-1:0] cal_reps,
   output scg_state_e       state,
   output logic             err_flag,
   output logic             flush
);
   localparam int LW = CNT_W + 1;
   localparam logic [LW-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("scg_cal_seq: CNT_W must be at least 1");
      end
   endgenerate

   scg_state_e       state_q, nxt;
   logic [CNT_W-1:0] len_q, reps_q;
   logic [LW-1:0]    slot_q, rep_q, len_eff, reps_eff;
   logic             cfg_ok_q, pend_q, err_q, load, cal_end;

   assign len_eff  = (len_q == '0)  ? FULL_CNT : {1'b0, len_q};
   assign reps_eff = (reps_q == '0) ? FULL_CNT : {1'b0, reps_q};
   assign load     = (state_q == ST_OFF) && (resync_req || !cfg_ok_q);
   assign flush    = (state_q == ST_OFF) && resync_req;
   assign cal_end  = (slot_q == '0) && (rep_q == '0);
   assign state    = state_q;
   assign err_flag = err_q;

   always_comb begin
      nxt = state_q;
      unique case (state_q)
         ST_OFF:  nxt = (resync_req || err_q) ? ST_OFF : ST_FRM;
         ST_FRM:  nxt = ST_CAL;
         ST_CAL:  nxt = cal_end ? ST_DIP : ST_CAL;
         ST_DIP:  nxt = (pend_q || resync_req) ? ST_OFF : ST_FRM;
         default: nxt = ST_OFF;
      endcase
      if (fault) nxt = ST_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_OFF;
         len_q    <= '0;
         reps_q   <= '0;
         cfg_ok_q <= 1'b0;
         pend_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         state_q <= nxt;
         if (load) begin
            len_q    <= cal_len;
            reps_q   <= cal_reps;
            cfg_ok_q <= 1'b1;
         end
         if (state_q == ST_OFF) pend_q <= 1'b0;
         else if (resync_req)   pend_q <= 1'b1;
         if (fault)      err_q <= 1'b1;
         else if (flush) err_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         rep_q  <= '0;
      end else if (state_q == ST_FRM) begin
         slot_q <= len_eff - LW'(1);
         rep_q  <= reps_eff - LW'(1);
      end else if (state_q == ST_CAL) begin
         if (slot_q != '0) begin
            slot_q <= slot_q - LW'(1);
         end else if (rep_q != '0) begin
            rep_q  <= rep_q - LW'(1);
            slot_q <= len_eff - LW'(1);
         end
      end
   end
endmodule

// File: rtl/scg_dip2.sv
module scg_dip2 #(
   parameter int WORD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              acc_en,
   input  logic [WORD_W-1:0] word,
   input  logic              inject,
   input  logic              dip_cyc,
   output logic [WORD_W-1:0] dip_word
);
   logic [WORD_W-1:0] acc;
   logic              inj_d_q, arm_q, rise;

   assign rise = inject && !inj_d_q;

   for (genvar b = 0; b < WORD_W; b++) begin : g_lane
      logic lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      lane_q <= 1'b0;
         else if (clr)    lane_q <= 1'b0;
         else if (acc_en) lane_q <= lane_q ^ word[b];
      end
      assign acc[b] = lane_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inj_d_q <= 1'b0;
         arm_q   <= 1'b0;
      end else begin
         inj_d_q <= inject;
         arm_q   <= dip_cyc ? rise : (arm_q || rise);
      end
   end

   assign dip_word = ~acc ^ {WORD_W{arm_q}};
endmodule

// File: rtl/status_cal_gen.sv
module status_cal_gen
   import scg_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter int CNT_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             resync_req,
   input  logic             err_inject,
   input  logic [CNT_W-1:0] cal_len,
   input  logic [CNT_W-1:0] cal_reps,
   input  logic             stat_push,
   input  logic [1:0]       stat_wdata,
   output logic [1:0]       stat_out,
   output logic             stat_disabled,
   output logic             stat_dip_state,
   output logic             fifo_err
);
   scg_state_e        state;
   logic              flush, pop, empty, ovf, unf, fault, err_flag;
   logic [STAT_W-1:0] head, sent, dip_word;

   assign pop   = (state == ST_CAL);
   assign fault = ovf || unf;
   assign sent  = (head == FRAME_WORD) ? STARVE_WORD : head;

   scg_stat_fifo #(.DEPTH(FIFO_DEPTH), .WORD_W(STAT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(stat_push),
      .wdata(stat_wdata), .pop(pop), .rdata(head), .empty(empty),
      .ovf(ovf), .unf(unf)
   );

   scg_cal_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .resync_req(resync_req), .fault(fault),
      .cal_len(cal_len), .cal_reps(cal_reps), .state(state),
      .err_flag(err_flag), .flush(flush)
   );

   scg_dip2 #(.WORD_W(STAT_W)) u_dip (
      .clk(clk), .rst_n(rst_n), .clr(state == ST_FRM),
      .acc_en(pop && !empty), .word(sent), .inject(err_inject),
      .dip_cyc(state == ST_DIP), .dip_word(dip_word)
   );

   always_comb begin
      unique case (state)
         ST_CAL:  stat_out = empty ? FRAME_WORD : sent;
         ST_DIP:  stat_out = dip_word;
         default: stat_out = FRAME_WORD;
      endcase
   end

   assign stat_disabled  = (state == ST_OFF);
   assign stat_dip_state = (state == ST_DIP);
   assign fifo_err       = err_flag;
endmodule

// File: rtl/status_cal_gen_chk.sv
module status_cal_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       resync_req,
   input logic       err_inject,
   input logic [1:0] stat_out,
   input logic       stat_disabled,
   input logic       stat_dip_state,
   input logic       fifo_err
);
   logic [1:0] par_q;
   logic       inj_d_q, seen_q, rise, dip_bad;

   assign rise    = err_inject && !inj_d_q;
   assign dip_bad = stat_dip_state && (stat_out != ~par_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q   <= '0;
         inj_d_q <= 1'b0;
         seen_q  <= 1'b0;
      end else begin
         inj_d_q <= err_inject;
         seen_q  <= stat_dip_state ? rise : (seen_q || rise);
         if (stat_dip_state || stat_disabled || stat_out == 2'b11) par_q <= '0;
         else par_q <= par_q ^ stat_out;
      end
   end

   a_r1_framing_while_off: assert property (@(posedge clk) disable iff (!rst_n)
      stat_disabled |-> stat_out == 2'b11);
   a_r1_framing_after_dip: assert property (@(posedge clk) disable iff (!rst_n)
      stat_dip_state |=> stat_out == 2'b11);
   a_r5_dip_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      stat_dip_state |=> !stat_dip_state);
   a_r6_off_not_dip: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_disabled && stat_dip_state));
   a_r8_inject_once: assert property (@(posedge clk) disable iff (!rst_n)
      stat_dip_state |-> (dip_bad == seen_q));
   a_r9_fault_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_err) |-> stat_disabled);
   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_err && !resync_req) |=> fifo_err);
   a_r11_err_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_err |-> stat_disabled);
endmodule

bind status_cal_gen status_cal_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .resync_req(resync_req), .err_inject(err_inject),
   .stat_out(stat_out), .stat_disabled(stat_disabled),
   .stat_dip_state(stat_dip_state), .fifo_err(fifo_err)
);

// File: tb/status_cal_gen_tb.sv
module status_cal_gen_tb;
   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       resync_req = 1'b1;
   logic       err_inject = 1'b0;
   logic [7:0] cal_len = 8'd3;
   logic [7:0] cal_reps = 8'd2;
   logic       stat_push = 1'b0;
   logic [1:0] stat_wdata = 2'b00;
   logic [1:0] stat_out;
   logic       stat_disabled, stat_dip_state, fifo_err;

   always #10 clk = ~clk;

   status_cal_gen #(.FIFO_DEPTH(DEPTH), .CNT_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .resync_req(resync_req), .err_inject(err_inject),
      .cal_len(cal_len), .cal_reps(cal_reps), .stat_push(stat_push),
      .stat_wdata(stat_wdata), .stat_out(stat_out), .stat_disabled(stat_disabled),
      .stat_dip_state(stat_dip_state), .fifo_err(fifo_err)
   );

   int n_tests = 0, n_fail = 0;
   bit done = 0;
   int L, M, phase, lvl, qh, qt, tgt, dcount;
   logic [1:0] q [512];
   logic [1:0] acc;
   bit inj_pend, pend;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] gen_word(input int c);
      return 2'((c * 5 + (c >> 3)) & 3);
   endfunction

   function automatic logic [1:0] san(input logic [1:0] d);
      return (d == 2'b11) ? 2'b10 : d;
   endfunction

   task automatic push_one();
      logic [1:0] d;
      d = gen_word(dcount);
      dcount++;
      stat_push  = 1'b1;
      stat_wdata = d;
      q[qt % 512] = d;
      qt++;
      lvl++;
   endtask

   // Enter continuous framing, reload the configuration, then start a frame.
   task automatic start(input int l, input int m);
      resync_req = 1'b1;
      stat_push  = 1'b0;
      cal_len    = 8'(l);
      cal_reps   = 8'(m);
      while (!stat_disabled) @(negedge clk);
      chk(stat_out == 2'b11, "R1", stat_out, 3);
      @(negedge clk);
      chk(fifo_err == 1'b0, "R11", fifo_err, 0);
      chk(stat_disabled == 1'b1, "R6", stat_disabled, 1);
      resync_req = 1'b0;
      qh = 0; qt = 0; lvl = 0; pend = 0;
      L = (l == 0) ? 256 : l;
      M = (m == 0) ? 256 : m;
      push_one();
      phase = 0;
      @(negedge clk);
   endtask

   task automatic run(input int n, input int inj_at, input int inj_len, input int rs_at,
                      input int chg_at, input string ptag, input string etag);
      for (int k = 0; k < n; k++) begin
         logic [1:0] e;
         bit pop_now, fault, rs_now;
         int nxt;
         pop_now = 0; fault = 0;
         stat_push = 1'b0;
         if (phase < 0) begin
            chk(stat_disabled == 1'b1, (phase == -2) ? "R11" : "R6", stat_disabled, 1);
            chk(stat_out == 2'b11, "R1", stat_out, 3);
            chk(fifo_err == (phase == -2), (phase == -2) ? etag : "R11", fifo_err, int'(phase == -2));
         end else begin
            chk(stat_disabled == 1'b0, "R6", stat_disabled, 0);
            chk(fifo_err == 1'b0, etag, fifo_err, 0);
            if (phase == 0) begin
               chk(stat_out == 2'b11, "R1", stat_out, 3);
               chk(stat_dip_state == 1'b0, "R5", stat_dip_state, 0);
               acc = 2'b00;
            end else if (phase <= L * M) begin
               pop_now = 1;
               chk(stat_dip_state == 1'b0, ptag, stat_dip_state, 0);
               if (lvl == 0) begin
                  fault = 1;
                  chk(stat_out == 2'b11, etag, stat_out, 3);
               end else begin
                  e = san(q[qh % 512]);
                  chk(stat_out == e, "R3", stat_out, e);
                  acc = acc ^ e;
                  qh++;
                  lvl--;
               end
            end else begin
               e = ~acc ^ (inj_pend ? 2'b11 : 2'b00);
               chk(stat_out == e, inj_pend ? "R8" : "R4", stat_out, e);
               chk(stat_dip_state == 1'b1, ptag, stat_dip_state, 1);
               inj_pend = 0;
            end
            if (!fault && lvl < tgt) begin
               if (lvl == DEPTH && !pop_now) begin
                  fault = 1;
                  stat_push  = 1'b1;
                  stat_wdata = 2'b01;
               end else begin
                  push_one();
               end
            end
         end
         if (k == inj_at) begin
            if (!err_inject) inj_pend = 1;
            err_inject = 1'b1;
         end
         if (k == inj_at + inj_len) err_inject = 1'b0;
         if (k == chg_at) begin
            cal_len  = 8'd5;
            cal_reps = 8'd3;
         end
         rs_now = (k == rs_at);
         resync_req = rs_now;
         if (rs_now && phase != -1 && phase != -2) pend = 1;
         if (fault) nxt = -2;
         else if (phase == -2) nxt = -2;
         else if (phase == -1) begin
            pend = 0;
            nxt = rs_now ? -1 : 0;
         end else if (phase == L * M + 1) nxt = pend ? -1 : 0;
         else nxt = phase + 1;
         phase = nxt;
         @(negedge clk);
      end
      stat_push  = 1'b0;
      resync_req = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      dcount = 0; inj_pend = 0; pend = 0; tgt = 2;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(stat_disabled == 1'b1, "R6", stat_disabled, 1);
      chk(stat_out == 2'b11, "R1", stat_out, 3);
      chk(stat_dip_state == 1'b0, "R5", stat_dip_state, 0);
      chk(fifo_err == 1'b0, "R11", fifo_err, 0);

      // R4 parity and R8 one-shot injection held for 20 cycles
      start(3, 2);
      run(40, 10, 20, -1, -1, "R5", "R9");
      // R7: config change ignored while running; R6 resync pulse
      run(30, -1, 0, 12, 3, "R7", "R9");
      // R7 reload under resync, short frame
      start(2, 1);
      run(20, 5, 2, -1, -1, "R5", "R9");
      // R2: zero counts mean 256
      start(0, 1);
      run(530, -1, 0, -1, -1, "R2", "R9");
      start(1, 0);
      run(520, -1, 0, -1, -1, "R2", "R9");
      // R10 overflow, then sticky R11
      tgt = 5;
      start(3, 2);
      run(30, -1, 0, -1, -1, "R5", "R10");
      chk(phase == -2, "R10", phase, -2);
      // R9 underflow
      tgt = 0;
      start(3, 2);
      run(10, -1, 0, -1, -1, "R5", "R9");
      chk(phase == -2, "R9", phase, -2);
      // recovery
      tgt = 2;
      start(3, 2);
      run(20, -1, 0, -1, -1, "R5", "R9");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule